// File: doc/BRIEF.md
# Interleaved-Bank Section SAR Controller

This block sequences one converter section of a time-interleaved analog-to-digital bank. A bank sequencer fires a start pulse, and the section then runs a fixed frame of eighteen clock steps. The first three steps pulse, in turn, a strobe that samples the zero reference, a strobe for the auto-zero comparison, and a strobe for the calibration comparison. Step four connects the section to the analog input through the sample strobe. Steps five to seventeen carry out a 13-bit successive-approximation search, one bit per clock, driven by a single-bit comparator decision. Step eighteen hands the finished code to the bank's output multiplexer with a transfer strobe.

The capacitor array and the comparator sit outside the block. The block drives the trial code that the array converts, and it reads back one comparator bit per clock. That bit is 1 when the input is at or above the trial level. A start pulse given in the transfer step chains frames back to back, so a bank of eighteen sections can take one sample on every clock.

Top module: `sar_section_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, all five strobes are low and both trial_code and result_code are 0.
- R2: frame_start, sampled at a clock edge while the section is idle or in step 18, makes the next cycle step 1. zref_smp is high in that cycle.
- R3: az_cmp is high in step 2 only and cal_cmp in step 3 only. Each lasts exactly one cycle.
- R4: in_smp is high in step 4 only, and trial_code is 0 during that step.
- R5: In step 5, trial_code holds only its most significant bit (4096). In each following search step, the next lower bit is also set.
- R6: With cmp_ge = 1 meaning input >= trial_code, a bit is kept when the decision made during its step is 1 and cleared when it is 0. The transferred code equals the input level exactly: an input of 8191 gives 8191 and an input of 0 gives 0.
- R7: result_xfer is high for exactly the one cycle of step 18, with the new code on result_code. result_code holds that code until the next transfer.
- R8: frame_start during steps 1 to 17 has no effect. The frame in progress completes with its normal strobes, transfer timing and code.
- R9: A start in step 18 begins the next frame with no idle cycle, and the two codes transfer 18 cycles apart.
- R10: At most one of the five strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Start pulse from the bank sequencer |
| cmp_ge | input | 1 | Comparator decision, 1 when the input is at or above the trial level |
| zref_smp | output | 1 | Zero-reference sample strobe (step 1) |
| az_cmp | output | 1 | Auto-zero compare strobe (step 2) |
| cal_cmp | output | 1 | Calibration compare strobe (step 3) |
| in_smp | output | 1 | Input sample strobe (step 4) |
| trial_code | output | RES_W | Trial code for the capacitor array |
| result_code | output | RES_W | Last completed conversion code |
| result_xfer | output | 1 | Transfer strobe (step 18) |

## Verification
A step counter that slips shows up at once as a strobe in the wrong cycle, and the bench checks every strobe in every step of the frame. A search pointer or trial register that has gone wrong shows in trial_code as early as step 5. At the latest it shows in step 18, because every transferred code is compared exactly with its input level. Extreme, single-bit, all-bit and random levels force each bit both ways. A trial register that is not cleared would carry bits from the previous frame, and that is visible in step 4.

// File: rtl/sar_sec_pkg.sv
package sar_sec_pkg;
  // Number of steps in front of the search: zero ref, auto-zero, calibration, sample
  localparam int PRE_STEPS = 4;

  // Frame length for a given resolution: preamble, search bits, transfer
  function automatic int frame_len(input int res_w);
    return PRE_STEPS + res_w + 1;
  endfunction
endpackage

// File: rtl/sar_step_seq.sv
module sar_step_seq
  import sar_sec_pkg::*;
#(
  parameter int RES_W  = 13,
  parameter int STEP_W = $clog2(frame_len(RES_W) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [STEP_W-1:0] step_q,
  output logic [STEP_W-1:0] step_d
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(frame_len(RES_W));

  logic may_start;

  always_comb begin
    may_start = (step_q == '0) || (step_q == LAST);
    if (start && may_start)
      step_d = STEP_W'(1);
    else if (may_start)
      step_d = '0;
    else
      step_d = step_q + STEP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= step_d;
  end
endmodule

// File: rtl/sar_strobe_dec.sv
module sar_strobe_dec
  import sar_sec_pkg::*;
#(
  parameter int RES_W  = 13,
  parameter int STEP_W = $clog2(frame_len(RES_W) + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [STEP_W-1:0]    step_d,
  output logic [PRE_STEPS-1:0] pre_strb,
  output logic                 xfer_strb
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(frame_len(RES_W));

  // One registered strobe per preamble step, decoded from the next step
  for (genvar i = 0; i < PRE_STEPS; i++) begin : g_pre
    always_ff @(posedge clk) begin
      if (rst) pre_strb[i] <= 1'b0;
      else     pre_strb[i] <= (step_d == STEP_W'(i + 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) xfer_strb <= 1'b0;
    else     xfer_strb <= (step_d == LAST);
  end
endmodule

// File: rtl/sar_search.sv
module sar_search
  import sar_sec_pkg::*;
#(
  parameter int RES_W  = 13,
  parameter int STEP_W = $clog2(frame_len(RES_W) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] step_q,
  input  logic              cmp_ge,
  output logic [RES_W-1:0]  trial,
  output logic [RES_W-1:0]  result
);
  localparam logic [STEP_W-1:0] CLR_STEP  = STEP_W'(PRE_STEPS - 1);
  localparam logic [STEP_W-1:0] SMP_STEP  = STEP_W'(PRE_STEPS);
  localparam logic [STEP_W-1:0] CONV_LO   = STEP_W'(PRE_STEPS + 1);
  localparam logic [STEP_W-1:0] CONV_HI   = STEP_W'(PRE_STEPS + RES_W);
  localparam logic [RES_W-1:0]  MSB_ONLY  = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] ptr;       // one-hot: bit under test
  logic [RES_W-1:0] trial_nxt;
  logic             in_conv;

  assign in_conv   = (step_q >= CONV_LO) && (step_q <= CONV_HI);
  // drop the bit under test on a low decision, then raise the next lower bit
  assign trial_nxt = (trial & ~(ptr & {RES_W{~cmp_ge}})) | (ptr >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      trial  <= '0;
      ptr    <= '0;
      result <= '0;
    end else if (step_q == CLR_STEP) begin
      trial <= '0;
      ptr   <= '0;
    end else if (step_q == SMP_STEP) begin
      trial <= MSB_ONLY;
      ptr   <= MSB_ONLY;
    end else if (in_conv) begin
      trial <= trial_nxt;
      ptr   <= ptr >> 1;
      if (step_q == CONV_HI) result <= trial_nxt;
    end
  end
endmodule

// File: rtl/sar_section_ctrl.sv
module sar_section_ctrl
  import sar_sec_pkg::*;
#(
  parameter int RES_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             cmp_ge,
  output logic             zref_smp,
  output logic             az_cmp,
  output logic             cal_cmp,
  output logic             in_smp,
  output logic [RES_W-1:0] trial_code,
  output logic [RES_W-1:0] result_code,
  output logic             result_xfer
);
  localparam int STEP_W = $clog2(frame_len(RES_W) + 1);

  logic [STEP_W-1:0]    step_q, step_d;
  logic [PRE_STEPS-1:0] pre_strb;

  sar_step_seq #(.RES_W(RES_W), .STEP_W(STEP_W)) u_seq (
    .clk(clk), .rst(rst), .start(frame_start),
    .step_q(step_q), .step_d(step_d)
  );

  sar_strobe_dec #(.RES_W(RES_W), .STEP_W(STEP_W)) u_dec (
    .clk(clk), .rst(rst), .step_d(step_d),
    .pre_strb(pre_strb), .xfer_strb(result_xfer)
  );

  sar_search #(.RES_W(RES_W), .STEP_W(STEP_W)) u_srch (
    .clk(clk), .rst(rst), .step_q(step_q), .cmp_ge(cmp_ge),
    .trial(trial_code), .result(result_code)
  );

  assign zref_smp = pre_strb[0];
  assign az_cmp   = pre_strb[1];
  assign cal_cmp  = pre_strb[2];
  assign in_smp   = pre_strb[3];
endmodule

// File: rtl/sar_section_chk.sv
module sar_section_chk #(
  parameter int RES_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             zref_smp,
  input logic             az_cmp,
  input logic             cal_cmp,
  input logic             in_smp,
  input logic [RES_W-1:0] trial_code,
  input logic [RES_W-1:0] result_code,
  input logic             result_xfer
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({zref_smp, az_cmp, cal_cmp, in_smp, result_xfer}));

  // R3
  az_follows_chk: assert property (@(posedge clk) disable iff (rst)
    zref_smp |=> (az_cmp && !zref_smp));

  // R3
  cal_follows_chk: assert property (@(posedge clk) disable iff (rst)
    az_cmp |=> (cal_cmp && !az_cmp));

  // R4
  smp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    cal_cmp |=> in_smp);

  // R4
  trial_clear_chk: assert property (@(posedge clk) disable iff (rst)
    in_smp |-> (trial_code == '0));

  // R5
  msb_first_chk: assert property (@(posedge clk) disable iff (rst)
    in_smp |=> (trial_code == TOP_BIT));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !result_xfer |-> $stable(result_code));
endmodule

bind sar_section_ctrl sar_section_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .zref_smp(zref_smp), .az_cmp(az_cmp),
  .cal_cmp(cal_cmp), .in_smp(in_smp), .trial_code(trial_code),
  .result_code(result_code), .result_xfer(result_xfer)
);

// File: tb/sar_section_ctrl_tb.sv
module sar_section_ctrl_tb;
  localparam int RES_W = 13;
  localparam int NSTEP = RES_W + 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             frame_start = 1'b0;
  logic             cmp_ge;
  logic             zref_smp, az_cmp, cal_cmp, in_smp, result_xfer;
  logic [RES_W-1:0] trial_code, result_code;
  logic [RES_W-1:0] level = '0;

  int n_chk = 0;
  int n_bad = 0;
  int n_xfer = 0;
  int n_push = 0;
  int last_xfer_t = -1;
  int cyc = 0;
  bit done = 1'b0;
  logic [RES_W-1:0] exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // ideal comparator: 1 when the input level is at or above the trial level
  assign cmp_ge = (level >= trial_code);

  sar_section_ctrl #(.RES_W(RES_W)) u_dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .cmp_ge(cmp_ge),
    .zref_smp(zref_smp), .az_cmp(az_cmp), .cal_cmp(cal_cmp), .in_smp(in_smp),
    .trial_code(trial_code), .result_code(result_code), .result_xfer(result_xfer)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops the expected code on every transfer strobe
  always @(negedge clk) begin
    if (!rst && result_xfer) begin
      n_xfer++;
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected transfer", 1, 0);
      else chk(result_code == exp_q[0], "R6 transferred code", result_code, exp_q[0]);
      if (exp_q.size() != 0) void'(exp_q.pop_front());
      if (last_xfer_t >= 0 && cyc - last_xfer_t < NSTEP)
        chk(1'b0, "R9 transfer spacing", cyc - last_xfer_t, NSTEP);
      last_xfer_t = cyc;
    end
  end

  // driver: one frame; called at a negedge; leaves at the negedge of step 18
  task automatic run_frame(input logic [RES_W-1:0] t, input int inject);
    frame_start = 1'b1;
    level = t;
    exp_q.push_back(t);
    n_push++;
    for (int s = 1; s <= NSTEP; s++) begin
      @(negedge clk);
      frame_start = (s == inject);
      case (s)
        1: chk(zref_smp && !az_cmp, "R2 zero-ref strobe in step 1", zref_smp, 1);
        2: chk(az_cmp && !zref_smp, "R3 auto-zero strobe in step 2", az_cmp, 1);
        3: chk(cal_cmp && !az_cmp, "R3 calibration strobe in step 3", cal_cmp, 1);
        4: begin
          chk(in_smp && !cal_cmp, "R4 sample strobe in step 4", in_smp, 1);
          chk(trial_code == 0, "R4 trial cleared in step 4", trial_code, 0);
        end
        5: chk(trial_code == 13'h1000, "R5 MSB trial in step 5", trial_code, 4096);
        NSTEP: chk(result_xfer, "R7 transfer in step 18", result_xfer, 1);
        default: ;
      endcase
      if (s >= 5 && s < NSTEP)
        chk({zref_smp, az_cmp, cal_cmp, in_smp, result_xfer} == 0,
            (inject != 0) ? "R8 no strobe mid-frame" : "R10 no strobe in search",
            {zref_smp, az_cmp, cal_cmp, in_smp, result_xfer}, 0);
      if (s == 6)
        chk(trial_code == ((t & 13'h1000) | 13'h0800), "R5 second trial", trial_code,
            (t & 13'h1000) | 13'h0800);
    end
    frame_start = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_start = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({zref_smp, az_cmp, cal_cmp, in_smp, result_xfer} == 0, "R1 strobes in reset",
        {zref_smp, az_cmp, cal_cmp, in_smp, result_xfer}, 0);
    chk(trial_code == 0 && result_code == 0, "R1 codes in reset", trial_code | result_code, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({zref_smp, az_cmp, cal_cmp, in_smp, result_xfer} == 0, "R1 idle after reset",
        {zref_smp, az_cmp, cal_cmp, in_smp, result_xfer}, 0);
    idle(2);

    run_frame(13'h1FFF, 0);             // R6 full scale
    idle(3);
    chk(result_code == 13'h1FFF, "R7 code held after transfer", result_code, 8191);
    run_frame(13'h0000, 0);             // R6 zero
    idle(1);
    run_frame(13'h1000, 0);
    run_frame(13'h0FFF, 0);             // R9 back to back
    run_frame(13'h0001, 0);
    run_frame(13'h1555, 8);             // R8 start in step 8 ignored
    idle(2);
    chk(!zref_smp, "R8 no restart from mid-frame start", zref_smp, 0);
    run_frame(13'h0AAA, 1);             // R8 start in step 1 ignored
    idle(4);
    for (int k = 0; k < 40; k++) begin
      run_frame(RES_W'($urandom_range(0, 8191)), (k % 7 == 3) ? 12 : 0);
      if (k % 5 == 0) idle(k % 3);
    end
    idle(5);
    chk(n_xfer == n_push, "R7 one transfer per frame", n_xfer, n_push);
    chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule